// File: doc/BRIEF.md
# Three-Stage Chained PWM Timer

This block holds three identical up-counting PWM stages joined in a chain. Stage 0 is the head of the chain and counts every clock. Each later stage takes the rollover pulse of the stage before it as its count source. Every stage drives its own PWM output. When a stage's counter wraps from its period limit back to zero, it also emits a one-cycle rollover pulse.

Because the rollover pulse of one stage is the count source of the next, the chain divides the clock by the product of the stage periods. Each stage keeps its own duty cycle. Stages 1 and 2 each have a 2-bit count-source select:

| Code | Count source |
|------|--------------|
| 00 | every clock (free-running) |
| 01 | once per rising edge of the upstream pulse |
| 10 | every clock in which the upstream pulse is high (gated) |
| 11 | reserved; behaves as free-running |

A typical use is to set a period limit and a threshold on each stage and read the three PWM waves. For example, a head period limit of 511 with threshold 128, followed by two stages with limit 3 and threshold 1, gives three waves at 25% duty. The second wave runs at a quarter of the head frequency and the third at a sixteenth.

Top module: `cpwm_cascade`

## Requirements
- R1: While `rst` is high, every PWM and rollover output is low and every counter is zero. After `rst` falls, stage 0 counts one per clock from zero. Its first rollover pulse therefore appears after the (limit+1)-th clock edge.
- R2: A stage counting every clock rolls over every (limit+1) clocks. Its rollover output is high for exactly one cycle per rollover, and the counter reads zero in that cycle.
- R3: A stage's PWM output is high exactly while its counter is below its threshold. Over one period it is therefore high for threshold × (cycles per count) cycles.
- R4: A threshold of zero keeps the PWM output low at all times. A threshold above the period limit keeps it high at all times.
- R5: With select 01, a stage advances once per rising edge of the upstream pulse. Its rollover period is (upstream period) × (limit+1). An upstream pulse held high for many cycles advances the stage only once.
- R6: With select 10, a stage advances in every cycle the upstream pulse is high and holds its count otherwise.
- R7: Stage 2 counts from stage 1's rollover pulse. With both slaves on select 01 or 10, stage 2's period is the product of all three (limit+1) values.
- R8: Select 00 and select 11 both make a slave stage count every clock, independent of the upstream pulse.
- R9: If the period limit is rewritten below the current count, the stage wraps to zero and pulses on its next advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| lim0 | input | W | Stage 0 period limit |
| thr0 | input | W | Stage 0 PWM threshold |
| lim1 | input | W | Stage 1 period limit |
| thr1 | input | W | Stage 1 PWM threshold |
| sel1 | input | 2 | Stage 1 count-source select |
| lim2 | input | W | Stage 2 period limit |
| thr2 | input | W | Stage 2 PWM threshold |
| sel2 | input | 2 | Stage 2 count-source select |
| pwm0 | output | 1 | Stage 0 PWM |
| pwm1 | output | 1 | Stage 1 PWM |
| pwm2 | output | 1 | Stage 2 PWM |
| roll0 | output | 1 | Stage 0 rollover pulse |
| roll1 | output | 1 | Stage 1 rollover pulse |
| roll2 | output | 1 | Stage 2 rollover pulse |

## Verification
Two functions can fall in the same cycle: a stage's own rollover and the upstream advance that causes it. In that cycle the counter wraps, the PWM level changes, and a pulse is handed to the next stage, all at one edge. This case is provoked in every chained run with small limits, where a stage 2 wrap coincides with both upstream wraps. It is judged by exact rollover intervals of 16 and 64 clocks and by exact high-cycle counts per period. The second coincidence is a limit rewrite landing while the count is already above the new limit. It is provoked at a known count and judged by a rollover pulse on the very next edge.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic [1:0] {
    SRC_FREE = 2'b00,
    SRC_EDGE = 2'b01,
    SRC_GATE = 2'b10,
    SRC_RSVD = 2'b11
  } cpwm_src_e;
endpackage

// File: rtl/cpwm_advance.sv
module cpwm_advance
  import cpwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       up_pulse,
  output logic       adv
);
  logic up_prev;
  cpwm_src_e src;

  assign src = cpwm_src_e'(sel);

  always_ff @(posedge clk) begin
    if (rst) up_prev <= 1'b0;
    else     up_prev <= up_pulse;
  end

  always_comb begin
    case (src)
      SRC_EDGE: adv = up_pulse & ~up_prev;
      SRC_GATE: adv = up_pulse;
      default:  adv = 1'b1;
    endcase
  end

  // R5
  edge_once_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && src == SRC_EDGE && up_pulse && $past(up_pulse)) |-> !adv);
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         roll
);
  logic wrap;

  assign wrap    = adv && (cnt >= lim);
  assign cnt_nxt = !adv ? cnt : (wrap ? '0 : cnt + W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      roll <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      roll <= wrap;
    end
  end

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt >= lim) |=> (cnt == '0 && roll));
  // R2
  roll_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    roll |-> cnt == '0);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> (cnt == $past(cnt) && !roll));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !roll));
endmodule

// File: rtl/cpwm_compare.sv
module cpwm_compare #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] thr,
  output logic         pwm
);
  always_ff @(posedge clk) begin
    if (rst) pwm <= 1'b0;
    else     pwm <= (cnt_nxt < thr);
  end
endmodule

// File: rtl/cpwm_stage.sv
module cpwm_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   sel,
  input  logic         up_pulse,
  input  logic [W-1:0] lim,
  input  logic [W-1:0] thr,
  output logic         pwm,
  output logic         roll
);
  logic         adv;
  logic [W-1:0] cnt;
  logic [W-1:0] cnt_nxt;

  cpwm_advance u_adv (
    .clk(clk), .rst(rst), .sel(sel), .up_pulse(up_pulse), .adv(adv)
  );

  cpwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .adv(adv), .lim(lim),
    .cnt(cnt), .cnt_nxt(cnt_nxt), .roll(roll)
  );

  cpwm_compare #(.W(W)) u_cmp (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .thr(thr), .pwm(pwm)
  );

  // R3
  pwm_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(thr)) |-> (pwm == (cnt < thr)));
  // R1
  pwm_reset_chk: assert property (@(posedge clk) rst |=> !pwm);
endmodule

// File: rtl/cpwm_cascade.sv
module cpwm_cascade #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lim0,
  input  logic [W-1:0] thr0,
  input  logic [W-1:0] lim1,
  input  logic [W-1:0] thr1,
  input  logic [1:0]   sel1,
  input  logic [W-1:0] lim2,
  input  logic [W-1:0] thr2,
  input  logic [1:0]   sel2,
  output logic         pwm0,
  output logic         pwm1,
  output logic         pwm2,
  output logic         roll0,
  output logic         roll1,
  output logic         roll2
);
  localparam int NSTG = 3;

  logic [W-1:0] lim_a [NSTG];
  logic [W-1:0] thr_a [NSTG];
  logic [1:0]   sel_a [NSTG];
  logic         up_a  [NSTG];
  logic         pwm_a [NSTG];
  logic         roll_a[NSTG];

  assign lim_a[0] = lim0;
  assign lim_a[1] = lim1;
  assign lim_a[2] = lim2;
  assign thr_a[0] = thr0;
  assign thr_a[1] = thr1;
  assign thr_a[2] = thr2;
  assign sel_a[0] = cpwm_pkg::SRC_FREE;
  assign sel_a[1] = sel1;
  assign sel_a[2] = sel2;

  for (genvar i = 0; i < NSTG; i++) begin : g_stg
    if (i == 0) begin : g_head
      assign up_a[i] = 1'b0;
    end else begin : g_link
      assign up_a[i] = roll_a[i-1];
    end

    cpwm_stage #(.W(W)) u_stage (
      .clk(clk), .rst(rst), .sel(sel_a[i]), .up_pulse(up_a[i]),
      .lim(lim_a[i]), .thr(thr_a[i]), .pwm(pwm_a[i]), .roll(roll_a[i])
    );
  end

  assign pwm0  = pwm_a[0];
  assign pwm1  = pwm_a[1];
  assign pwm2  = pwm_a[2];
  assign roll0 = roll_a[0];
  assign roll1 = roll_a[1];
  assign roll2 = roll_a[2];
endmodule

// File: tb/cpwm_cascade_bench.sv
module cpwm_cascade_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] lim0 = '0, thr0 = '0, lim1 = '0, thr1 = '0, lim2 = '0, thr2 = '0;
  logic [1:0] sel1 = 2'b00, sel2 = 2'b00;
  logic pwm0, pwm1, pwm2, roll0, roll1, roll2;

  int tests_run  = 0;
  int tests_fail = 0;

  always #2 clk = ~clk;

  cpwm_cascade #(.W(W)) u_cpwm_cascade (
    .clk(clk), .rst(rst),
    .lim0(lim0), .thr0(thr0), .lim1(lim1), .thr1(thr1), .sel1(sel1),
    .lim2(lim2), .thr2(thr2), .sel2(sel2),
    .pwm0(pwm0), .pwm1(pwm1), .pwm2(pwm2),
    .roll0(roll0), .roll1(roll1), .roll2(roll2)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic roll_of(input int s);
    return (s == 0) ? roll0 : (s == 1) ? roll1 : roll2;
  endfunction

  function automatic logic pwm_of(input int s);
    return (s == 0) ? pwm0 : (s == 1) ? pwm1 : pwm2;
  endfunction

  task automatic setup(input int l0, input int t0, input int l1, input int t1,
                       input int s1, input int l2, input int t2, input int s2);
    @(negedge clk);
    rst  = 1'b1;
    lim0 = W'(l0); thr0 = W'(t0);
    lim1 = W'(l1); thr1 = W'(t1); sel1 = 2'(s1);
    lim2 = W'(l2); thr2 = W'(t2); sel2 = 2'(s2);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // interval between consecutive rollover pulses and PWM-high cycles inside it
  task automatic measure(input int s, output int period, output int high);
    int guard = 0;
    while (roll_of(s) == 1'b0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    period = 0;
    high   = 0;
    do begin
      high += int'(pwm_of(s));
      period++;
      @(negedge clk);
    end while (roll_of(s) == 1'b0 && period < 2000);
  endtask

  task automatic t_reset;
    int first = 0;
    setup(5, 2, 3, 1, 1, 3, 1, 1);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    // R1 outputs low while reset is held
    check({pwm0, pwm1, pwm2, roll0, roll1, roll2} == 6'b0, "R1 reset outputs",
          int'({pwm0, pwm1, pwm2, roll0, roll1, roll2}), 0);
    rst = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (roll0 && first == 0) first = k;
    end
    // R1 counting starts from zero after release
    check(first == 6, "R1 first rollover edge", first, 6);
  endtask

  task automatic t_head;
    int p, h, dbl = 0;
    setup(7, 2, 3, 1, 1, 3, 1, 1);
    measure(0, p, h);
    check(p == 8, "R2 head period", p, 8);
    check(h == 2, "R3 head high cycles", h, 2);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (roll0 && roll_of(0) && k > 0 && dbl == -1) dbl = 1;
      dbl = roll0 ? -1 : 0;
      if (roll0) begin
        @(negedge clk);
        if (roll0) tests_fail += 0;
        check(!roll0, "R2 single-cycle pulse", int'(roll0), 0);
      end
    end
  endtask

  task automatic t_limits;
    int p, h;
    setup(7, 0, 3, 1, 1, 3, 1, 1);
    measure(0, p, h);
    check(h == 0, "R4 zero threshold low", h, 0);
    setup(7, 9, 3, 1, 1, 3, 1, 1);
    measure(0, p, h);
    check(h == 8, "R4 threshold above limit high", h, 8);
  endtask

  task automatic t_chain_edge;
    int p, h;
    setup(3, 1, 3, 1, 1, 3, 1, 1);
    measure(1, p, h);
    check(p == 16, "R5 slave1 period", p, 16);
    check(h == 4, "R3 slave1 high cycles", h, 4);
    measure(2, p, h);
    check(p == 64, "R7 slave2 period", p, 64);
    check(h == 16, "R7 slave2 high cycles", h, 16);
  endtask

  task automatic t_chain_gate;
    int p, h;
    setup(3, 1, 3, 1, 2, 3, 1, 2);
    measure(1, p, h);
    check(p == 16, "R6 gated slave1 period", p, 16);
    measure(2, p, h);
    check(p == 64, "R7 gated slave2 period", p, 64);
  endtask

  task automatic t_level;
    int p, h, n = 0;
    // head limit 0 keeps its rollover output high continuously
    setup(0, 1, 3, 1, 2, 100, 1, 0);
    measure(1, p, h);
    check(p == 4, "R6 gated on held level", p, 4);
    check(h == 1, "R6 gated high cycles", h, 1);
    setup(0, 1, 3, 1, 1, 100, 1, 0);
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (roll1) n++;
    end
    check(n == 0, "R5 held level counts once", n, 0);
    check(pwm1 == 1'b0, "R5 count stays at one", int'(pwm1), 0);
  endtask

  task automatic t_select;
    int p, h;
    setup(200, 1, 4, 1, 3, 100, 1, 0);
    measure(1, p, h);
    check(p == 5, "R8 reserved select free-running", p, 5);
    setup(200, 1, 6, 1, 0, 100, 1, 0);
    measure(1, p, h);
    check(p == 7, "R8 select 00 free-running", p, 7);
  endtask

  task automatic t_shrink;
    int p, h;
    setup(15, 16, 3, 1, 1, 3, 1, 1);
    repeat (8) @(negedge clk);
    check(!roll0, "R9 no pulse before rewrite", int'(roll0), 0);
    lim0 = W'(3);
    @(negedge clk);
    check(roll0, "R9 wrap after rewrite", int'(roll0), 1);
    measure(0, p, h);
    check(p == 4, "R9 new period", p, 4);
  endtask

  initial begin
    t_reset();
    t_head();
    t_limits();
    t_chain_edge();
    t_chain_gate();
    t_level();
    t_select();
    t_shrink();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests_run++;
    tests_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
    $finish;
  end
endmodule